// File: doc/BRIEF.md
# NoC Packet Transmit Unit with Send DMA

This block is the sending side of a network interface. It sits between a processor bus and a 2D-mesh router. The processor fills a small set of registers over a memory-mapped port that takes writes and gives combinational reads. Writing the command register starts a packet. The block takes a snapshot of the destination, tag and data registers and builds a 64-bit head flit from them. The command byte becomes the type field of that flit.

A SINGLE packet is the head flit alone, with the 32-bit data register as its payload. A BLOCK packet carries a body-flit count N in the head. N comes from the low 16 bits of the data register. After the head, a send DMA reads N words from local memory, starting at the read start address, and sends each word as one body flit. Flits leave on a valid/ready stream. Memory is read through a read-enable and address port, and the data returns one cycle later.

Top module: `noc_pkt_tx`

## Requirements
- R1: After reset, flit_valid_o and mem_re_o are low, and the status register (offset 0x04) and every other register read as zero.
- R2: A write completes in one cycle, and the register reads back its masked value on the next cycle. The destination register (0x08) keeps bits [7:0], the tag register (0x0C) keeps bits [15:0], and the data register (0x10) and read start address (0x14) keep all 32 bits.
- R3: The head flit has this layout: type (the command byte written to offset 0x00) in [63:56], destination in [55:48] (Δx in [55:52], Δy in [51:48]), tag in [47:32], and payload in [31:0]. When command bit 0 is 0 the packet is SINGLE: the payload is the data register, and no flit follows the head.
- R4: For a SINGLE packet, if the command write is presented in cycle k, flit_valid_o first rises in cycle k+4.
- R5: When command bit 0 is 1 the packet is BLOCK. The head payload is {16'h0, data[15:0]}, and the head first becomes valid in cycle k+5.
- R6: After a BLOCK head is accepted, the block sends N body flits. Body flit i is {32'h0, word read at address start+i}. The address is a word address, issued on mem_re_o, and it advances by one for each accepted body flit.
- R7: A BLOCK packet with N = 0 sends only the head and makes no memory read.
- R8: While flit_valid_o is high and flit_ready_i is low, flit_valid_o stays high and flit_data_o does not change.
- R9: Status bit 0 (busy) is high from the cycle after the command write until the last flit of the packet is accepted. A command write while busy starts no packet and sets status bit 1 (overrun). Bit 1 stays set until reset.
- R10: A write to the destination, tag, data or start-address register during a packet does not change the flits of that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register byte offset |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data for bus_addr_i |
| flit_valid_o | output | 1 | Flit valid toward router |
| flit_ready_i | input | 1 | Router accepts flit |
| flit_data_o | output | 64 | Flit payload |
| mem_re_o | output | 1 | Memory read enable |
| mem_addr_o | output | MADDR_W | Memory word address |
| mem_rdata_i | input | 32 | Memory read data, one cycle after mem_re_o |

## Verification
A wrong latency count shows up at once as a head flit rising in the wrong cycle, one edge early or late. A corrupted DMA address or remaining count appears within one body flit: the wrong memory address is issued, a body word differs from the expected one, or there are too many or too few flits before busy drops. A sequencer that leaves or re-enters its idle state at the wrong time shows within a few cycles as a busy bit that stays stuck. A dropped overrun or a second command that is not ignored shows as an extra unexpected flit.

// File: rtl/noc_tx_pkg.sv
package noc_tx_pkg;
  localparam int FLIT_W = 64;
  localparam int WORD_W = 32;
  localparam int TYPE_W = 8;
  localparam int DEST_W = 8;
  localparam int TAG_W  = 16;
  localparam int LEN_W  = 16;

  // byte offsets decoded by software; fixed
  localparam logic [7:0] OFF_CMD   = 8'h00;
  localparam logic [7:0] OFF_STAT  = 8'h04;
  localparam logic [7:0] OFF_DEST  = 8'h08;
  localparam logic [7:0] OFF_TAG   = 8'h0C;
  localparam logic [7:0] OFF_DATA  = 8'h10;
  localparam logic [7:0] OFF_RADDR = 8'h14;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_HEAD, ST_FETCH, ST_CAP, ST_BODY
  } tx_state_e;

  function automatic logic [FLIT_W-1:0] make_head(
    input logic [TYPE_W-1:0] typ,
    input logic [DEST_W-1:0] dest,
    input logic [TAG_W-1:0]  tag,
    input logic [WORD_W-1:0] data,
    input logic              blk
  );
    logic [WORD_W-1:0] pay;
    pay = blk ? {{(WORD_W-LEN_W){1'b0}}, data[LEN_W-1:0]} : data;
    return {typ, dest, tag, pay};
  endfunction
endpackage

// File: rtl/noc_tx_regs.sv
module noc_tx_regs
  import noc_tx_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int MADDR_W = 32
)(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_we_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [WORD_W-1:0]    bus_wdata_i,
  output logic [WORD_W-1:0]    bus_rdata_o,
  input  logic                 busy_i,
  output logic                 launch_o,
  output logic [TYPE_W-1:0]    launch_type_o,
  output logic [DEST_W-1:0]    dest_o,
  output logic [TAG_W-1:0]     tag_o,
  output logic [WORD_W-1:0]    data_o,
  output logic [MADDR_W-1:0]   raddr_o
);
  logic [TYPE_W-1:0] cmd_q;
  logic              ovr_q;
  logic              hit_cmd;

  assign hit_cmd       = bus_we_i && (bus_addr_i == ADDR_W'(OFF_CMD));
  assign launch_o      = hit_cmd && !busy_i;
  assign launch_type_o = bus_wdata_i[TYPE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      ovr_q   <= 1'b0;
      dest_o  <= '0;
      tag_o   <= '0;
      data_o  <= '0;
      raddr_o <= '0;
    end else begin
      if (launch_o) cmd_q <= bus_wdata_i[TYPE_W-1:0];
      if (hit_cmd && busy_i) ovr_q <= 1'b1;
      if (bus_we_i) begin
        if (bus_addr_i == ADDR_W'(OFF_DEST))  dest_o  <= bus_wdata_i[DEST_W-1:0];
        if (bus_addr_i == ADDR_W'(OFF_TAG))   tag_o   <= bus_wdata_i[TAG_W-1:0];
        if (bus_addr_i == ADDR_W'(OFF_DATA))  data_o  <= bus_wdata_i;
        if (bus_addr_i == ADDR_W'(OFF_RADDR)) raddr_o <= MADDR_W'(bus_wdata_i);
      end
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if      (bus_addr_i == ADDR_W'(OFF_CMD))   bus_rdata_o = WORD_W'(cmd_q);
    else if (bus_addr_i == ADDR_W'(OFF_STAT))  bus_rdata_o = WORD_W'({ovr_q, busy_i});
    else if (bus_addr_i == ADDR_W'(OFF_DEST))  bus_rdata_o = WORD_W'(dest_o);
    else if (bus_addr_i == ADDR_W'(OFF_TAG))   bus_rdata_o = WORD_W'(tag_o);
    else if (bus_addr_i == ADDR_W'(OFF_DATA))  bus_rdata_o = data_o;
    else if (bus_addr_i == ADDR_W'(OFF_RADDR)) bus_rdata_o = WORD_W'(raddr_o);
  end

  // R9
  ovr_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_cmd && busy_i) |=> (bus_addr_i != ADDR_W'(OFF_STAT)) || bus_rdata_o[1]);
endmodule

// File: rtl/noc_tx_dma.sv
module noc_tx_dma
  import noc_tx_pkg::*;
#(
  parameter int MADDR_W = 32
)(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                launch_i,
  input  logic [MADDR_W-1:0]  start_i,
  input  logic [LEN_W-1:0]    count_i,
  input  logic                fetch_i,
  input  logic                cap_i,
  input  logic                body_acc_i,
  input  logic [WORD_W-1:0]   mem_rdata_i,
  output logic                mem_re_o,
  output logic [MADDR_W-1:0]  mem_addr_o,
  output logic [WORD_W-1:0]   word_o,
  output logic                rem_zero_o,
  output logic                rem_last_o
);
  logic [MADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]   rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      rem_q  <= '0;
      word_o <= '0;
    end else begin
      if (launch_i) begin
        addr_q <= start_i;
        rem_q  <= count_i;
      end else if (body_acc_i) begin
        addr_q <= addr_q + MADDR_W'(1);
        rem_q  <= rem_q - LEN_W'(1);
      end
      if (cap_i) word_o <= mem_rdata_i;
    end
  end

  assign mem_re_o   = fetch_i;
  assign mem_addr_o = addr_q;
  assign rem_zero_o = (rem_q == '0);
  assign rem_last_o = (rem_q == LEN_W'(1));

  // R6 R7
  dma_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |-> (rem_q != '0));
endmodule

// File: rtl/noc_tx_seq.sv
module noc_tx_seq
  import noc_tx_pkg::*;
#(
  parameter int LAT_SINGLE = 4,
  parameter int LAT_BLOCK  = 5
)(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               launch_i,
  input  logic [TYPE_W-1:0]  launch_type_i,
  input  logic [DEST_W-1:0]  dest_i,
  input  logic [TAG_W-1:0]   tag_i,
  input  logic [WORD_W-1:0]  data_i,
  input  logic               flit_ready_i,
  input  logic [WORD_W-1:0]  word_i,
  input  logic               rem_zero_i,
  input  logic               rem_last_i,
  output logic               flit_valid_o,
  output logic [FLIT_W-1:0]  flit_data_o,
  output logic               fetch_o,
  output logic               cap_o,
  output logic               body_acc_o,
  output logic               busy_o
);
  localparam int LAT_MAX = (LAT_BLOCK > LAT_SINGLE) ? LAT_BLOCK : LAT_SINGLE;
  localparam int CNT_W   = $clog2(LAT_MAX);

  tx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [FLIT_W-1:0] head_q;
  logic              blk_q;
  logic              launch_blk;

  assign launch_blk = launch_type_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      head_q  <= '0;
      blk_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (launch_i) begin
          state_q <= ST_ARM;
          cnt_q   <= launch_blk ? CNT_W'(LAT_BLOCK - 2) : CNT_W'(LAT_SINGLE - 2);
          head_q  <= make_head(launch_type_i, dest_i, tag_i, data_i, launch_blk);
          blk_q   <= launch_blk;
        end
        ST_ARM: begin
          if (cnt_q == '0) state_q <= ST_HEAD;
          else             cnt_q   <= cnt_q - CNT_W'(1);
        end
        ST_HEAD: if (flit_ready_i)
          state_q <= (blk_q && !rem_zero_i) ? ST_FETCH : ST_IDLE;
        ST_FETCH: state_q <= ST_CAP;
        ST_CAP:   state_q <= ST_BODY;
        ST_BODY: if (flit_ready_i)
          state_q <= rem_last_i ? ST_IDLE : ST_FETCH;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign flit_valid_o = (state_q == ST_HEAD) || (state_q == ST_BODY);
  assign flit_data_o  = (state_q == ST_HEAD) ? head_q
                                             : {{(FLIT_W-WORD_W){1'b0}}, word_i};
  assign fetch_o      = (state_q == ST_FETCH);
  assign cap_o        = (state_q == ST_CAP);
  assign body_acc_o   = (state_q == ST_BODY) && flit_ready_i;
  assign busy_o       = (state_q != ST_IDLE);

  // R8
  flit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flit_valid_o && !flit_ready_i) |=> (flit_valid_o && $stable(flit_data_o)));
  // R9
  valid_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flit_valid_o |-> busy_o);
  // R3
  single_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_HEAD) && flit_ready_i && !blk_q) |=> !flit_valid_o);
  // R4 R5
  arm_no_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !flit_valid_o);
endmodule

// File: rtl/noc_pkt_tx.sv
module noc_pkt_tx
  import noc_tx_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int MADDR_W    = 32,
  parameter int LAT_SINGLE = 4,
  parameter int LAT_BLOCK  = 5
)(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [WORD_W-1:0]   bus_wdata_i,
  output logic [WORD_W-1:0]   bus_rdata_o,
  output logic                flit_valid_o,
  input  logic                flit_ready_i,
  output logic [FLIT_W-1:0]   flit_data_o,
  output logic                mem_re_o,
  output logic [MADDR_W-1:0]  mem_addr_o,
  input  logic [WORD_W-1:0]   mem_rdata_i
);
  logic               launch, busy, fetch, cap, body_acc, rem_zero, rem_last;
  logic [TYPE_W-1:0]  launch_type;
  logic [DEST_W-1:0]  dest;
  logic [TAG_W-1:0]   tag;
  logic [WORD_W-1:0]  data, word;
  logic [MADDR_W-1:0] raddr;

  noc_tx_regs #(.ADDR_W(ADDR_W), .MADDR_W(MADDR_W)) i_regs (
    .clk_i, .rst_ni, .bus_we_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .busy_i(busy), .launch_o(launch), .launch_type_o(launch_type),
    .dest_o(dest), .tag_o(tag), .data_o(data), .raddr_o(raddr)
  );

  noc_tx_dma #(.MADDR_W(MADDR_W)) i_dma (
    .clk_i, .rst_ni, .launch_i(launch), .start_i(raddr),
    .count_i(data[LEN_W-1:0]), .fetch_i(fetch), .cap_i(cap),
    .body_acc_i(body_acc), .mem_rdata_i, .mem_re_o, .mem_addr_o,
    .word_o(word), .rem_zero_o(rem_zero), .rem_last_o(rem_last)
  );

  noc_tx_seq #(.LAT_SINGLE(LAT_SINGLE), .LAT_BLOCK(LAT_BLOCK)) i_seq (
    .clk_i, .rst_ni, .launch_i(launch), .launch_type_i(launch_type),
    .dest_i(dest), .tag_i(tag), .data_i(data), .flit_ready_i,
    .word_i(word), .rem_zero_i(rem_zero), .rem_last_i(rem_last),
    .flit_valid_o, .flit_data_o, .fetch_o(fetch), .cap_o(cap),
    .body_acc_o(body_acc), .busy_o(busy)
  );
endmodule

// File: tb/test_noc_pkt_tx.sv
module test_noc_pkt_tx;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0, bus_rdata_o;
  logic        flit_valid_o, flit_ready_i = 1'b1;
  logic [63:0] flit_data_o;
  logic        mem_re_o;
  logic [31:0] mem_addr_o, mem_rdata_i = '0;

  noc_pkt_tx i_noc_pkt_tx (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_tests = 0, n_fail = 0, cyc = 0;
  int cmd_cyc = 0, exp_lat = 0, rd_cnt = 0;
  bit lat_pending = 0, hold_prev = 0, done = 0;
  logic [63:0] prev_data = '0;
  logic [31:0] rd_next = '0;
  int rdy_mode = 0;
  logic [63:0] exp_q[$];

  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A00, ~a[15:0]};
  endfunction

  always @(posedge clk_i) if (mem_re_o) mem_rdata_i <= mem_word(mem_addr_o);

  always @(negedge clk_i)
    case (rdy_mode)
      0: flit_ready_i <= 1'b1;
      1: flit_ready_i <= 1'($urandom_range(0, 1));
      default: flit_ready_i <= 1'b0;
    endcase

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    #(CLK_PERIOD/4);
    if (rst_ni) begin
      if (lat_pending && flit_valid_o) begin
        check(cyc - cmd_cyc == exp_lat, exp_lat == 4 ? "R4" : "R5", "head latency",
              64'(cyc - cmd_cyc), 64'(exp_lat));
        lat_pending = 0;
      end
      if (hold_prev)
        check(flit_valid_o && flit_data_o == prev_data, "R8", "hold under stall",
              flit_data_o, prev_data);
      hold_prev = flit_valid_o && !flit_ready_i;
      prev_data = flit_data_o;
      if (flit_valid_o && flit_ready_i) begin
        if (exp_q.size() == 0) check(0, "R9", "unexpected flit", flit_data_o, 64'h0);
        else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          check(flit_data_o == e, "R3 R6", "flit", flit_data_o, e);
        end
      end
      if (mem_re_o) begin
        rd_cnt++;
        check(mem_addr_o == rd_next, "R6", "dma address", 64'(mem_addr_o), 64'(rd_next));
        rd_next++;
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(posedge clk_i); #1;
    bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    bus_addr_i = a;
    #(CLK_PERIOD/4);
    d = bus_rdata_o;
  endtask

  task automatic send(input logic [7:0] cmd, input logic [7:0] dest,
                      input logic [15:0] tag, input logic [31:0] data,
                      input logic [31:0] raddr);
    wr(8'h08, 32'(dest)); wr(8'h0C, 32'(tag)); wr(8'h10, data); wr(8'h14, raddr);
    if (cmd[0]) begin
      exp_q.push_back({cmd, dest, tag, 16'h0, data[15:0]});
      for (int i = 0; i < int'(data[15:0]); i++)
        exp_q.push_back({32'h0, mem_word(raddr + 32'(i))});
    end else exp_q.push_back({cmd, dest, tag, data});
    rd_next = raddr;
    @(negedge clk_i);
    cmd_cyc = cyc; exp_lat = cmd[0] ? 5 : 4; lat_pending = 1;
    bus_we_i = 1'b1; bus_addr_i = 8'h00; bus_wdata_i = 32'(cmd);
    @(posedge clk_i); #1;
    bus_we_i = 1'b0;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(8'h04, s);
      if (exp_q.size() == 0 && !s[0]) break;
    end
    check(exp_q.size() == 0, "R9", "packet drained", 64'(exp_q.size()), 64'h0);
  endtask

  initial begin
    logic [31:0] v;
    int base;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(!flit_valid_o && !mem_re_o, "R1", "outputs idle", {flit_valid_o, mem_re_o}, 0);
    rd(8'h04, v); check(v == 0, "R1", "status", v, 0);
    rd(8'h10, v); check(v == 0, "R1", "data reg", v, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    // R2 masking and readback
    wr(8'h08, 32'hABCD12F3); rd(8'h08, v); check(v == 32'hF3, "R2", "dest", v, 32'hF3);
    wr(8'h0C, 32'hFFFF5A5A); rd(8'h0C, v); check(v == 32'h5A5A, "R2", "tag", v, 32'h5A5A);
    wr(8'h14, 32'h8000_0123); rd(8'h14, v); check(v == 32'h8000_0123, "R2", "raddr", v, 32'h8000_0123);
    // R3 R4 single
    send(8'h10, 8'h21, 16'h1234, 32'hDEADBEEF, 32'h0);
    wait_done();
    check(rd_cnt == 0, "R3", "no reads for single", 64'(rd_cnt), 0);
    // R5 R6 block, upper data half ignored in count
    base = rd_cnt;
    send(8'h81, 8'hF1, 16'hBEEF, 32'hABCD0003, 32'h10);
    wait_done();
    check(rd_cnt - base == 3, "R6", "read count", 64'(rd_cnt - base), 3);
    // R7 empty block
    base = rd_cnt;
    send(8'h03, 8'h12, 16'h0007, 32'hFFFF0000, 32'h55);
    wait_done();
    check(rd_cnt == base, "R7", "no reads for N=0", 64'(rd_cnt - base), 0);
    // R8 random backpressure
    rdy_mode = 1;
    send(8'h41, 8'h3C, 16'hCAFE, 32'h0000_0005, 32'h200);
    wait_done();
    send(8'h22, 8'h0F, 16'h0101, 32'h1357_9BDF, 32'h0);
    wait_done();
    // R9 R10 overrun and writes during busy
    rdy_mode = 2;
    base = rd_cnt;
    send(8'h05, 8'h44, 16'h4444, 32'h0000_0004, 32'h40);
    repeat (10) @(negedge clk_i);
    rd(8'h04, v); check(v[0] == 1'b1, "R9", "busy while stalled", v, 1);
    wr(8'h08, 32'h99); wr(8'h0C, 32'h9999); wr(8'h10, 32'h2); wr(8'h14, 32'h900);
    wr(8'h00, 32'h07);
    rd(8'h04, v); check(v[1:0] == 2'b11, "R9", "overrun set", v, 3);
    rdy_mode = 0;
    wait_done();
    check(rd_cnt - base == 4, "R10", "old count and address used", 64'(rd_cnt - base), 4);
    repeat (12) @(negedge clk_i);
    rd(8'h04, v); check(v == 32'h2, "R9", "idle, overrun sticky", v, 2);
    check(!flit_valid_o, "R9", "ignored command sent nothing", 64'(flit_valid_o), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule